// File: doc/BRIEF.md
# SPI Register-Access Transaction Monitor

This block watches a four-wire SPI bus between a host and a radio transceiver and never drives it. The clock, chip select and both data lines are brought into the system clock domain through two-flop synchronizers. Data is sampled on rising SCK edges, most significant bit first (mode 0), and assembled into bytes. Each burst with chip select low is split into commands. A command is short (two bytes) when bit 7 of its first byte is clear, and long (three bytes) when that bit is set.

For every completed command the monitor pulses `evt_valid_o` for one cycle. With that pulse it presents the frame type, the direction, the register address, the data byte and a region code. For long commands the region code names the buffer or register area the address falls in. A chip-select release that cuts a command short after a single byte raises a separate one-cycle warning. Any partial command is always thrown away when chip select goes high.

Top module: `spi_access_monitor`

## Requirements
- R1: With chip select low, a command whose first MOSI byte has bit 7 = 0 completes after its second byte and produces exactly one `evt_valid_o` pulse with `evt_long_o` = 0.
- R2: For a short command, `evt_addr_o` = {4'b0, first byte bits 6:1} and `evt_write_o` = first byte bit 0.
- R3: A command whose first byte has bit 7 = 1 completes after its third byte with `evt_long_o` = 1. The first two bytes form a 16-bit word W (first byte in the upper half), with `evt_addr_o` = W[14:5] and `evt_write_o` = W[4].
- R4: On a write, `evt_data_o` is the MOSI byte of the last position of the command (byte 2 short, byte 3 long). On a read, it is the MISO byte captured in that same position. The other line's byte in that position has no effect.
- R5: For long commands, `evt_region_o` is 0 below 0x080, 1 for 0x080-0x0FF, 2 for 0x100-0x17F, 3 for 0x180-0x1FF, 4 for 0x200-0x27F, 5 for 0x280-0x2BF, 6 for 0x2C0-0x2FF and 7 for 0x300 and up.
- R6: Short commands report `evt_region_o` = 0.
- R7: After a command completes, the next byte starts a new command while chip select stays low, so several commands may share one burst.
- R8: When chip select rises with exactly one byte of the current command collected, `warn_cs_o` pulses for one cycle and no event is produced.
- R9: When chip select rises with no byte, or with two bytes of a long command collected, no warning and no event are produced, and the partial command is discarded.
- R10: Chip select high clears the bit counter, so a burst ending mid-byte leaves no bits behind for the next burst.
- R11: After reset, `evt_valid_o` and `warn_cs_o` are 0.
- R12: `evt_valid_o` and `warn_cs_o` never stay high for two consecutive cycles and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock (asynchronous) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Host-to-device data |
| miso_i | input | 1 | Device-to-host data |
| evt_valid_o | output | 1 | One-cycle pulse per completed command |
| evt_long_o | output | 1 | 1 for a three-byte command |
| evt_write_o | output | 1 | 1 for a write command |
| evt_addr_o | output | 10 | Register or buffer address |
| evt_data_o | output | 8 | Data byte of the command |
| evt_region_o | output | 3 | Address region code (0 for short) |
| warn_cs_o | output | 1 | One-cycle pulse on a chip-select release after one byte |

## Verification
A wrong byte or bit count inside the monitor shows at the ports as a misaligned command. The address and data fields shift by bits or bytes, or the type is wrong, on the very next event after the fault. The fault can also show as a missing or extra event, or as a spurious warning at the next chip-select release. A stuck frame counter shows within one burst, because a second command sharing the same chip-select window decodes wrongly. A partial command left over after release shows as corrupt fields on the first event of the following burst.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHORT_AW = 6;
  localparam int LONG_AW  = 10;
  localparam int REGION_W = 3;

  typedef enum logic [REGION_W-1:0] {
    RG_TX_NORM = 3'd0,
    RG_BEACON  = 3'd1,
    RG_SLOT1   = 3'd2,
    RG_SLOT2   = 3'd3,
    RG_CTRL    = 3'd4,
    RG_KEYS    = 3'd5,
    RG_RSVD    = 3'd6,
    RG_RX      = 3'd7
  } region_e;

  typedef struct packed {
    logic               is_long;
    logic               is_write;
    logic [LONG_AW-1:0] addr;
    logic [BYTE_W-1:0]  data;
    region_e            region;
  } evt_t;
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_rise_i,
  input  logic          cs_hi_i,
  input  logic          mosi_i,
  input  logic          miso_i,
  output logic          byte_vld_o,
  output logic [BW-1:0] mosi_byte_o,
  output logic [BW-1:0] miso_byte_o
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [CW-1:0] bit_cnt_q;
  logic [BW-1:0] mosi_sh_q, miso_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q   <= '0;
      mosi_sh_q   <= '0;
      miso_sh_q   <= '0;
      byte_vld_o  <= 1'b0;
      mosi_byte_o <= '0;
      miso_byte_o <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (cs_hi_i) begin
        bit_cnt_q <= '0;
      end else if (sck_rise_i) begin
        mosi_sh_q <= {mosi_sh_q[BW-2:0], mosi_i};
        miso_sh_q <= {miso_sh_q[BW-2:0], miso_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST) begin
          bit_cnt_q   <= '0;
          byte_vld_o  <= 1'b1;
          mosi_byte_o <= {mosi_sh_q[BW-2:0], mosi_i};
          miso_byte_o <= {miso_sh_q[BW-2:0], miso_i};
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_dec.sv
module spi_frame_dec
  import spi_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] mosi_byte_i,
  input  logic [BYTE_W-1:0] miso_byte_i,
  input  logic              cs_rise_i,
  output logic              evt_vld_o,
  output evt_t              evt_o,
  output logic              warn_o
);
  localparam int PAD_W = LONG_AW - SHORT_AW;

  logic [1:0]        cnt_q, cnt_nxt;
  logic [BYTE_W-1:0] b0_q, b1_q;
  logic              done, done_long, wr;
  logic [LONG_AW-1:0] addr;
  region_e           region;

  function automatic region_e classify(input logic [LONG_AW-1:0] a);
    unique case (a[LONG_AW-1 -: 3])
      3'd0:    return RG_TX_NORM;
      3'd1:    return RG_BEACON;
      3'd2:    return RG_SLOT1;
      3'd3:    return RG_SLOT2;
      3'd4:    return RG_CTRL;
      3'd5:    return a[LONG_AW-4] ? RG_RSVD : RG_KEYS;
      default: return RG_RX;
    endcase
  endfunction

  always_comb begin
    done_long = (cnt_q == 2'd2);
    done      = byte_vld_i && (done_long || (cnt_q == 2'd1 && !b0_q[BYTE_W-1]));
    wr        = done_long ? b1_q[4] : b0_q[0];
    addr      = done_long ? {b0_q[6:0], b1_q[7:5]} : {{PAD_W{1'b0}}, b0_q[6:1]};
    region    = done_long ? classify(addr) : RG_TX_NORM;
    cnt_nxt   = cnt_q;
    if (byte_vld_i) cnt_nxt = done ? 2'd0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      b0_q      <= '0;
      b1_q      <= '0;
      evt_vld_o <= 1'b0;
      evt_o     <= '0;
      warn_o    <= 1'b0;
    end else begin
      cnt_q     <= cs_rise_i ? 2'd0 : cnt_nxt;
      warn_o    <= cs_rise_i && (cnt_nxt == 2'd1);
      evt_vld_o <= done;
      if (byte_vld_i && cnt_q == 2'd0) b0_q <= mosi_byte_i;
      if (byte_vld_i && cnt_q == 2'd1) b1_q <= mosi_byte_i;
      if (done) begin
        evt_o.is_long  <= done_long;
        evt_o.is_write <= wr;
        evt_o.addr     <= addr;
        evt_o.data     <= wr ? mosi_byte_i : miso_byte_i;
        evt_o.region   <= region;
      end
    end
  end
endmodule

// File: rtl/spi_access_monitor.sv
module spi_access_monitor
  import spi_mon_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic                mosi_i,
  input  logic                miso_i,
  output logic                evt_valid_o,
  output logic                evt_long_o,
  output logic                evt_write_o,
  output logic [LONG_AW-1:0]  evt_addr_o,
  output logic [BYTE_W-1:0]   evt_data_o,
  output logic [REGION_W-1:0] evt_region_o,
  output logic                warn_cs_o
);
  logic [3:0] pins_s;
  logic       sck_s, cs_s, mosi_s, miso_s;
  logic       sck_d_q, cs_d_q;
  logic       byte_vld;
  logic [BYTE_W-1:0] mosi_byte, miso_byte;
  evt_t       evt;

  spi_mon_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i, miso_i}),
    .q_o   (pins_s)
  );
  assign {sck_s, cs_s, mosi_s, miso_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
    end else begin
      sck_d_q <= sck_s;
      cs_d_q  <= cs_s;
    end
  end

  spi_byte_rx #(.BW(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (sck_s & ~sck_d_q),
    .cs_hi_i    (cs_s),
    .mosi_i     (mosi_s),
    .miso_i     (miso_s),
    .byte_vld_o (byte_vld),
    .mosi_byte_o(mosi_byte),
    .miso_byte_o(miso_byte)
  );

  spi_frame_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .mosi_byte_i(mosi_byte),
    .miso_byte_i(miso_byte),
    .cs_rise_i  (cs_s & ~cs_d_q),
    .evt_vld_o  (evt_valid_o),
    .evt_o      (evt),
    .warn_o     (warn_cs_o)
  );

  assign evt_long_o   = evt.is_long;
  assign evt_write_o  = evt.is_write;
  assign evt_addr_o   = evt.addr;
  assign evt_data_o   = evt.data;
  assign evt_region_o = evt.region;
endmodule

// File: rtl/spi_access_monitor_chk.sv
module spi_access_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_o,
  input logic       evt_long_o,
  input logic [9:0] evt_addr_o,
  input logic [2:0] evt_region_o,
  input logic       warn_cs_o
);
  a_r12_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);
  a_r12_warn_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_cs_o |=> !warn_cs_o);
  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(warn_cs_o && evt_valid_o));
  a_r6_short_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_long_o) |-> evt_region_o == 3'd0);
  a_r2_short_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_long_o) |-> evt_addr_o[9:6] == 4'd0);
  a_r5_rx_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_long_o && evt_addr_o[9:8] == 2'b11) |-> evt_region_o == 3'd7);
endmodule

bind spi_access_monitor spi_access_monitor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_o (evt_valid_o),
  .evt_long_o  (evt_long_o),
  .evt_addr_o  (evt_addr_o),
  .evt_region_o(evt_region_o),
  .warn_cs_o   (warn_cs_o)
);

// File: tb/spi_access_monitor_bench.sv
module spi_access_monitor_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso = 1'b0;
  logic       evt_valid, evt_long, evt_write, warn_cs;
  logic [9:0] evt_addr;
  logic [7:0] evt_data;
  logic [2:0] evt_region;

  int tests = 0, fails = 0, warn_seen = 0;
  logic prev_valid = 1'b0, prev_warn = 1'b0;
  logic [22:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  spi_access_monitor u_spi_access_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_i(miso),
    .evt_valid_o(evt_valid), .evt_long_o(evt_long), .evt_write_o(evt_write),
    .evt_addr_o(evt_addr), .evt_data_o(evt_data), .evt_region_o(evt_region),
    .warn_cs_o(warn_cs)
  );

  function automatic logic [2:0] exp_region(input logic [9:0] a);
    if (a < 10'h080) return 3'd0;
    if (a < 10'h100) return 3'd1;
    if (a < 10'h180) return 3'd2;
    if (a < 10'h200) return 3'd3;
    if (a < 10'h280) return 3'd4;
    if (a < 10'h2C0) return 3'd5;
    if (a < 10'h300) return 3'd6;
    return 3'd7;
  endfunction

  // monitor: scoreboard pop and pulse-width checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected event got %h expected none",
                   {evt_long, evt_write, evt_addr, evt_data, evt_region});
        end else begin
          logic [22:0] e, g;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          g = {evt_long, evt_write, evt_addr, evt_data, evt_region};
          if (g !== e) begin
            fails++;
            $display("FAIL %s event got %h expected %h", t, g, e);
          end
        end
      end
      if (warn_cs) warn_seen++;
      if ((evt_valid && prev_valid) || (warn_cs && prev_warn) || (evt_valid && warn_cs)) begin
        tests++; fails++;
        $display("FAIL R12 pulses v=%b pv=%b w=%b pw=%b expected single exclusive",
                 evt_valid, prev_valid, warn_cs, prev_warn);
      end
      prev_valid = evt_valid;
      prev_warn  = warn_cs;
    end
  end

  task automatic xfer_bits(input logic [7:0] mo, input logic [7:0] mi, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = mo[i]; miso = mi[i];
      repeat (8) @(posedge clk);
      sck = 1'b1;
      repeat (8) @(posedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer_byte(input logic [7:0] mo, input logic [7:0] mi);
    xfer_bits(mo, mi, 8);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic cs_high();
    repeat (8) @(posedge clk);
    cs_n = 1'b1;
    repeat (16) @(posedge clk);
  endtask

  task automatic short_acc(input logic wr, input logic [5:0] a, input logic [7:0] d,
                           input logic [7:0] other, input string t);
    exp_q.push_back({1'b0, wr, 4'd0, a, d, 3'd0});
    tag_q.push_back(t);
    xfer_byte({1'b0, a, wr}, 8'h5A);
    if (wr) xfer_byte(d, other); else xfer_byte(other, d);
  endtask

  task automatic long_acc(input logic wr, input logic [9:0] a, input logic [7:0] d,
                          input logic [7:0] other, input string t);
    logic [15:0] w;
    w = {1'b1, a, wr, 4'h0};
    exp_q.push_back({1'b1, wr, a, d, exp_region(a)});
    tag_q.push_back(t);
    xfer_byte(w[15:8], 8'hC3);
    xfer_byte(w[7:0], 8'h3C);
    if (wr) xfer_byte(d, other); else xfer_byte(other, d);
  endtask

  task automatic check_int(input int got, input int exp, input string t);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", t, got, exp);
    end
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          fails++; tests++;
          $display("FAIL watchdog got timeout expected completion");
          $display("  [TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none

    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (evt_valid !== 1'b0 || warn_cs !== 1'b0) begin
      fails++;
      $display("FAIL R11 got v=%b w=%b expected 0 0", evt_valid, warn_cs);
    end

    // R1 R2 R4 short write and read, opposite line ignored
    cs_low(); short_acc(1'b1, 6'h2A, 8'hA5, 8'hFF, "R1_R2_R4 short write"); cs_high();
    cs_low(); short_acc(1'b0, 6'h3F, 8'h81, 8'h7E, "R2_R4 short read"); cs_high();
    cs_low(); short_acc(1'b1, 6'h00, 8'h00, 8'hFF, "R6 short addr0"); cs_high();

    // R3 R4 R5 long accesses across every region and its edges
    cs_low(); long_acc(1'b1, 10'h07F, 8'h11, 8'hEE, "R3_R5 tx normal"); cs_high();
    cs_low(); long_acc(1'b0, 10'h080, 8'h22, 8'hDD, "R4_R5 beacon"); cs_high();
    cs_low(); long_acc(1'b1, 10'h17F, 8'h33, 8'h00, "R5 slot1"); cs_high();
    cs_low(); long_acc(1'b0, 10'h180, 8'h44, 8'hFF, "R5 slot2"); cs_high();
    cs_low(); long_acc(1'b1, 10'h27F, 8'h55, 8'h00, "R5 control"); cs_high();
    cs_low(); long_acc(1'b0, 10'h280, 8'h66, 8'h99, "R5 keys"); cs_high();
    cs_low(); long_acc(1'b1, 10'h2C0, 8'h77, 8'h00, "R5 reserved"); cs_high();
    cs_low(); long_acc(1'b0, 10'h300, 8'h88, 8'h01, "R5 rx low"); cs_high();
    cs_low(); long_acc(1'b1, 10'h3FF, 8'h99, 8'h00, "R3_R5 rx top"); cs_high();

    // R7 several commands in one burst
    cs_low();
    short_acc(1'b1, 6'h15, 8'h3C, 8'h00, "R7 burst short");
    long_acc(1'b0, 10'h1A5, 8'hC7, 8'h12, "R7 burst long");
    short_acc(1'b0, 6'h01, 8'h6E, 8'hAA, "R7 burst short2");
    cs_high();
    check_int(exp_q.size(), 0, "R7 queue drained");

    // R8 release after one byte
    cs_low(); xfer_byte(8'h05, 8'h00); cs_high();
    check_int(warn_seen, 1, "R8 warn after one byte");
    // R8 long after first byte
    cs_low(); xfer_byte(8'h85, 8'h00); cs_high();
    check_int(warn_seen, 2, "R8 warn after one long byte");
    // R9 no byte, and long cut after two bytes
    cs_low(); cs_high();
    check_int(warn_seen, 2, "R9 empty burst no warn");
    cs_low(); xfer_byte(8'h80, 8'h00); xfer_byte(8'h10, 8'h00); cs_high();
    check_int(warn_seen, 2, "R9 two long bytes no warn");
    // R9 partial discarded: next burst decodes as fresh command
    cs_low(); short_acc(1'b1, 6'h09, 8'hB4, 8'h00, "R9 fresh after discard"); cs_high();

    // R10 partial bits dropped on release
    cs_low(); xfer_bits(8'hFF, 8'hFF, 5); cs_high();
    check_int(warn_seen, 2, "R10 partial bits no warn");
    cs_low(); short_acc(1'b0, 6'h12, 8'h4D, 8'h00, "R10 clean byte after partial"); cs_high();

    repeat (20) @(posedge clk);
    check_int(exp_q.size(), 0, "R1 all expected events seen");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule